// File: doc/BRIEF.md
# Battery-Chain Readback Frame Parser

This block takes the 32-bit words that come back from a daisy chain of battery-monitor devices and turns each one into decoded fields in a single registered step. A word is either a conversion result, which carries a 12-bit value, or a register readback, which carries an 8-bit value. The caller chooses which by driving `frm_kind` alongside the word. Each word holds an 8-bit checksum. The block checks it and can also compare the echoed device and register address against an expected address. It reports one error code per word.

While a scan runs, the block keeps a running total of the cell-voltage results, which are channels 0 to 5 of each device. Auxiliary channels are left out of the total. Every conversion result is also checked against a pair of programmable limits, one pair for cells and one for auxiliary inputs. A result that crosses a limit gives a one-cycle rising or falling event. A scan-start strobe clears the total. The serial transport that delivers the words is outside this block.

Top module: `cellchain_frame_parser`

## Requirements
- R1: With `frm_kind`=0 (conversion result), the word gives device = bits 31:27, channel = bits 26:23 (4 bits, zero-extended onto `out_addr`) and result = bits 22:11 on `out_data`.
- R2: With `frm_kind`=1 (register readback), the word gives device = bits 31:27, register = bits 26:21 on `out_addr` and value = bits 20:13 on `out_data[7:0]`, with `out_data[11:8]` at 0.
- R3: The checksum is CRC-8 with polynomial x^8+x^5+x^3+x^2+x+1, computed over bits 31:10 taken as {2'b00, bits 31:10}. The 16 upper bits are multiplied by x^8 and reduced, and the result is XORed with the low byte. It must equal bits 9:2. On a mismatch `out_err`=1 (I/O error), and this takes priority over an address fault.
- R4: When `addr_chk_en`=1 and the checksum is good, `out_err`=2 (address fault) if the device field differs from `exp_dev`, or if the address field differs from `exp_addr`. The address comparison uses `exp_addr[3:0]` for conversion results and all 6 bits for register readbacks. When `addr_chk_en`=0, `out_err` is 0 for good words.
- R5: Only conversion results with channel 0 to 5 and a good checksum add their 12-bit result to `out_sum`. Channels 6 and up, register readbacks and checksum failures leave it unchanged. An address fault does not stop the addition.
- R6: `scan_clr` clears `out_sum` at the next edge. A word accepted in the same cycle adds into the cleared total.
- R7: For a cell result (channel 0 to 5), `ev_rise` pulses if result >= cell-high. Otherwise `ev_fall` pulses if result <= cell-low. Rising has priority, so both never pulse together.
- R8: A result on channel 6 or higher is compared in the same way against the auxiliary high/low pair. The cell limits play no part in it.
- R9: A pulse on `thr_wr` writes `thr_val` into the limit selected by `thr_sel` (0 cell-high, 1 cell-low, 2 aux-high, 3 aux-low). After reset the high limits are 0xFF and the low limits are 0.
- R10: Register readbacks and words with a checksum failure never raise `ev_rise` or `ev_fall`.
- R11: All outputs are registered. `out_valid` pulses in the cycle after `frm_valid`, and the events are only ever high together with `out_valid`.
- R12: `out_sum` holds the full-scale total of 8 devices x 6 cells x 4095 = 196560 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Word present this cycle |
| frm_data | input | 32 | Received word |
| frm_kind | input | 1 | 0 conversion result, 1 register readback |
| scan_clr | input | 1 | Start of scan, clears the total |
| addr_chk_en | input | 1 | Enable echoed-address comparison |
| exp_dev | input | 5 | Expected device field |
| exp_addr | input | 6 | Expected channel/register field |
| thr_wr | input | 1 | Limit write strobe |
| thr_sel | input | 2 | Limit select |
| thr_val | input | 8 | Limit value |
| out_valid | output | 1 | Decoded word valid |
| out_kind | output | 1 | Kind of the decoded word |
| out_dev | output | 5 | Decoded device field |
| out_addr | output | 6 | Decoded channel/register field |
| out_data | output | 12 | Decoded result or value |
| out_err | output | 2 | 0 none, 1 I/O error, 2 address fault |
| out_sum | output | SUM_W (18) | Running cell-voltage total |
| ev_rise | output | 1 | Upper-limit event |
| ev_fall | output | 1 | Lower-limit event |

## Verification
The hardest case to reach is the order of the rules when they overlap. Examples are a word that has both a broken checksum and a wrong address, a clear that lands in the same cycle as a word, and a pair of limits where high is at or below low. The bench builds every word itself with a correct checksum, using its own long-division routine, and then breaks single bits or addresses on purpose. This lets each overlap be produced exactly. The full-scale total needs 48 maximum-value cell words in one scan, and the bench generates them in a loop.

// File: rtl/ccfp_pkg.sv
package ccfp_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_IO   = 2'd1,
    ERR_ADDR = 2'd2
  } ccfp_err_t;

  localparam logic       KIND_CHAN = 1'b0;
  localparam logic       KIND_REG  = 1'b1;
  localparam logic [7:0] CRC_POLY  = 8'h2F;

  // one byte through eight shift/reduce steps
  function automatic logic [7:0] crc_byte(input logic [7:0] x);
    logic [7:0] c;
    c = x;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

  // checksum over a 22-bit payload (word bits 31:10)
  function automatic logic [7:0] frame_crc(input logic [21:0] p);
    logic [7:0] c;
    c = crc_byte({2'b00, p[21:16]});
    c = crc_byte(c ^ p[15:8]);
    return c ^ p[7:0];
  endfunction
endpackage

// File: rtl/ccfp_decode.sv
module ccfp_decode
  import ccfp_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic [31:0]      word,
  input  logic             kind,
  input  logic             chk_en,
  input  logic [4:0]       exp_dev,
  input  logic [5:0]       exp_addr,
  output logic [4:0]       dev,
  output logic [5:0]       addr,
  output logic [RES_W-1:0] data,
  output logic             crc_ok,
  output logic [1:0]       err
);
  logic addr_bad;

  always_comb begin
    dev    = word[31:27];
    crc_ok = (frame_crc(word[31:10]) == word[9:2]);
    if (kind == KIND_CHAN) begin
      addr     = {2'b00, word[26:23]};
      data     = word[22:11];
      addr_bad = (word[26:23] != exp_addr[3:0]);
    end else begin
      addr     = word[26:21];
      data     = {{(RES_W-8){1'b0}}, word[20:13]};
      addr_bad = (word[26:21] != exp_addr);
    end
    if (!crc_ok)
      err = ERR_IO;
    else if (chk_en && (addr_bad || (word[31:27] != exp_dev)))
      err = ERR_ADDR;
    else
      err = ERR_NONE;
  end
endmodule

// File: rtl/ccfp_thresh.sv
module ccfp_thresh #(
  parameter int RES_W = 12,
  parameter int THR_W = 8,
  parameter int NCELL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [THR_W-1:0] val,
  input  logic             judge,
  input  logic [5:0]       ch,
  input  logic [RES_W-1:0] res,
  output logic             rise,
  output logic             fall
);
  localparam int NLIM = 4;
  logic [THR_W-1:0] lim [NLIM];

  // index bit 0: low limit, index bit 1: auxiliary pair
  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    localparam logic [THR_W-1:0] RST_V = (g % 2 == 0) ? {THR_W{1'b1}} : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        lim[g] <= RST_V;
      else if (wr && (sel == 2'(g)))
        lim[g] <= val;
    end
  end

  logic             is_aux;
  logic [RES_W-1:0] hi, lo;
  always_comb begin
    is_aux = (ch >= 6'(NCELL));
    hi     = RES_W'(lim[{is_aux, 1'b0}]);
    lo     = RES_W'(lim[{is_aux, 1'b1}]);
    rise   = judge && (res >= hi);
    fall   = judge && !(res >= hi) && (res <= lo);
  end
endmodule

// File: rtl/ccfp_accum.sv
module ccfp_accum #(
  parameter int RES_W = 12,
  parameter int SUM_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [RES_W-1:0] res,
  output logic [SUM_W-1:0] sum
);
  logic [SUM_W-1:0] base;
  always_comb base = clr ? '0 : sum;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sum <= '0;
    else if (clr || add)
      sum <= base + (add ? SUM_W'(res) : '0);
  end
endmodule

// File: rtl/cellchain_frame_parser.sv
module cellchain_frame_parser
  import ccfp_pkg::*;
#(
  parameter int NDEV  = 8,
  parameter int NCELL = 6,
  parameter int RES_W = 12,
  parameter int THR_W = 8,
  parameter int SUM_W = $clog2(NDEV * NCELL * ((1 << RES_W) - 1) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [31:0]      frm_data,
  input  logic             frm_kind,
  input  logic             scan_clr,
  input  logic             addr_chk_en,
  input  logic [4:0]       exp_dev,
  input  logic [5:0]       exp_addr,
  input  logic             thr_wr,
  input  logic [1:0]       thr_sel,
  input  logic [THR_W-1:0] thr_val,
  output logic             out_valid,
  output logic             out_kind,
  output logic [4:0]       out_dev,
  output logic [5:0]       out_addr,
  output logic [RES_W-1:0] out_data,
  output logic [1:0]       out_err,
  output logic [SUM_W-1:0] out_sum,
  output logic             ev_rise,
  output logic             ev_fall
);
  // named internal events, brought out for the checker
  logic [4:0]       dec_dev;
  logic [5:0]       dec_addr;
  logic [RES_W-1:0] dec_data;
  logic             crc_ok_w;
  logic [1:0]       dec_err;
  logic             judge_w;
  logic             add_w;
  logic             rise_w, fall_w;

  ccfp_decode #(.RES_W(RES_W)) u_dec (
    .word    (frm_data),
    .kind    (frm_kind),
    .chk_en  (addr_chk_en),
    .exp_dev (exp_dev),
    .exp_addr(exp_addr),
    .dev     (dec_dev),
    .addr    (dec_addr),
    .data    (dec_data),
    .crc_ok  (crc_ok_w),
    .err     (dec_err)
  );

  assign judge_w = frm_valid && (frm_kind == KIND_CHAN) && crc_ok_w;
  assign add_w   = judge_w && (dec_addr < 6'(NCELL));

  ccfp_thresh #(.RES_W(RES_W), .THR_W(THR_W), .NCELL(NCELL)) u_thr (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (thr_wr),
    .sel  (thr_sel),
    .val  (thr_val),
    .judge(judge_w),
    .ch   (dec_addr),
    .res  (dec_data),
    .rise (rise_w),
    .fall (fall_w)
  );

  ccfp_accum #(.RES_W(RES_W), .SUM_W(SUM_W)) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (scan_clr),
    .add  (add_w),
    .res  (dec_data),
    .sum  (out_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= KIND_CHAN;
      out_dev   <= '0;
      out_addr  <= '0;
      out_data  <= '0;
      out_err   <= ERR_NONE;
      ev_rise   <= 1'b0;
      ev_fall   <= 1'b0;
    end else begin
      out_valid <= frm_valid;
      ev_rise   <= rise_w;
      ev_fall   <= fall_w;
      if (frm_valid) begin
        out_kind <= frm_kind;
        out_dev  <= dec_dev;
        out_addr <= dec_addr;
        out_data <= dec_data;
        out_err  <= dec_err;
      end
    end
  end
endmodule

// File: rtl/ccfp_checker.sv
module ccfp_checker #(
  parameter int RES_W = 12,
  parameter int SUM_W = 18,
  parameter int NCELL = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             scan_clr,
  input logic             out_valid,
  input logic             out_kind,
  input logic [5:0]       out_addr,
  input logic [RES_W-1:0] out_data,
  input logic [1:0]       out_err,
  input logic [SUM_W-1:0] out_sum,
  input logic             ev_rise,
  input logic             ev_fall
);
  a_r7_no_double_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rise && ev_fall));

  a_r11_event_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rise || ev_fall) |-> out_valid);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> out_valid);

  a_r10_no_event_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_err == 2'd1 || out_kind)) |-> !(ev_rise || ev_fall));

  a_r2_reg_data_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind) |-> (out_data[RES_W-1:8] == '0));

  a_r5_sum_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_clr && !frm_valid) |=> $stable(out_sum));

  a_r5_aux_no_add: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_kind && out_addr >= 6'(NCELL) && !$past(scan_clr))
      |-> $stable(out_sum));
endmodule

bind cellchain_frame_parser ccfp_checker #(
  .RES_W(RES_W), .SUM_W(SUM_W), .NCELL(NCELL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frm_valid(frm_valid),
  .scan_clr (scan_clr),
  .out_valid(out_valid),
  .out_kind (out_kind),
  .out_addr (out_addr),
  .out_data (out_data),
  .out_err  (out_err),
  .out_sum  (out_sum),
  .ev_rise  (ev_rise),
  .ev_fall  (ev_fall)
);

// File: tb/cellchain_frame_parser_test.sv
module cellchain_frame_parser_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_valid, frm_kind, scan_clr, addr_chk_en, thr_wr;
  logic [31:0] frm_data;
  logic [4:0]  exp_dev;
  logic [5:0]  exp_addr;
  logic [1:0]  thr_sel;
  logic [7:0]  thr_val;
  logic        out_valid, out_kind, ev_rise, ev_fall;
  logic [4:0]  out_dev;
  logic [5:0]  out_addr;
  logic [11:0] out_data;
  logic [1:0]  out_err;
  logic [17:0] out_sum;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cellchain_frame_parser uut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_kind(frm_kind), .scan_clr(scan_clr), .addr_chk_en(addr_chk_en),
    .exp_dev(exp_dev), .exp_addr(exp_addr), .thr_wr(thr_wr),
    .thr_sel(thr_sel), .thr_val(thr_val), .out_valid(out_valid),
    .out_kind(out_kind), .out_dev(out_dev), .out_addr(out_addr),
    .out_data(out_data), .out_err(out_err), .out_sum(out_sum),
    .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // long-division form of the checksum
  function automatic logic [7:0] ref_crc(input logic [21:0] p);
    logic [23:0] r;
    r = {2'b00, p[21:8], 8'h00};
    for (int i = 23; i >= 8; i--)
      if (r[i]) r = r ^ (24'h12F << (i - 8));
    return r[7:0] ^ p[7:0];
  endfunction

  function automatic logic [31:0] seal(input logic [31:0] w);
    logic [31:0] f;
    f = w;
    f[9:2] = ref_crc(w[31:10]);
    return f;
  endfunction

  function automatic logic [31:0] mk_chan(input logic [4:0] d, input logic [3:0] c,
                                          input logic [11:0] r);
    return seal({d, c, r, 11'b0});
  endfunction

  function automatic logic [31:0] mk_reg(input logic [4:0] d, input logic [5:0] a,
                                         input logic [7:0] v);
    return seal({d, a, v, 13'b0});
  endfunction

  // drive one word; outputs are sampled at the following falling edge
  task automatic send(input logic [31:0] w, input logic k, input logic clr);
    @(negedge clk);
    frm_valid = 1'b1; frm_data = w; frm_kind = k; scan_clr = clr;
    @(negedge clk);
    frm_valid = 1'b0; scan_clr = 1'b0;
  endtask

  task automatic clear_sum();
    @(negedge clk); scan_clr = 1'b1;
    @(negedge clk); scan_clr = 1'b0;
  endtask

  task automatic set_lim(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk); thr_wr = 1'b1; thr_sel = s; thr_val = v;
    @(negedge clk); thr_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset valid", out_valid, 0);
    chk("R12 reset sum", out_sum, 0);
    chk("R11 reset events", {ev_rise, ev_fall}, 0);
  endtask

  task automatic t_chan_decode();
    addr_chk_en = 1; exp_dev = 5'h13; exp_addr = 6'd3;
    send(mk_chan(5'h13, 4'd3, 12'hABC), 1'b0, 1'b0);
    chk("R11 valid pulse", out_valid, 1);
    chk("R1 dev", out_dev, 5'h13);
    chk("R1 chan", out_addr, 3);
    chk("R1 result", out_data, 12'hABC);
    chk("R1 err", out_err, 0);
    @(negedge clk);
    chk("R11 valid drops", out_valid, 0);
  endtask

  task automatic t_reg_decode();
    addr_chk_en = 1; exp_dev = 5'h04; exp_addr = 6'h1D;
    send(mk_reg(5'h04, 6'h1D, 8'h5A), 1'b1, 1'b0);
    chk("R2 dev", out_dev, 5'h04);
    chk("R2 reg", out_addr, 6'h1D);
    chk("R2 value", out_data, 12'h05A);
    chk("R2 kind", out_kind, 1);
    chk("R2 err", out_err, 0);
    chk("R10 reg no event", {ev_rise, ev_fall}, 0);
  endtask

  task automatic t_crc();
    logic [17:0] s0;
    clear_sum();
    send(mk_chan(5'h01, 4'd0, 12'h010), 1'b0, 1'b0);
    s0 = out_sum;
    chk("R5 base add", s0, 12'h010);
    addr_chk_en = 1; exp_dev = 5'h01; exp_addr = 6'd0;
    send(mk_chan(5'h01, 4'd0, 12'hFFF) ^ 32'h0010_0000, 1'b0, 1'b0);
    chk("R3 crc error", out_err, 1);
    chk("R3 sum held", out_sum, s0);
    chk("R10 crc no event", {ev_rise, ev_fall}, 0);
    exp_dev = 5'h02;
    send(mk_chan(5'h01, 4'd0, 12'h020) ^ 32'h0000_0004, 1'b0, 1'b0);
    chk("R3 crc over addr", out_err, 1);
  endtask

  task automatic t_addr();
    addr_chk_en = 1; exp_dev = 5'h02; exp_addr = 6'd1;
    send(mk_chan(5'h03, 4'd1, 12'h001), 1'b0, 1'b0);
    chk("R4 dev mismatch", out_err, 2);
    exp_dev = 5'h03; exp_addr = 6'h21;
    send(mk_chan(5'h03, 4'd1, 12'h001), 1'b0, 1'b0);
    chk("R4 chan uses 4 bits", out_err, 0);
    send(mk_reg(5'h03, 6'h01, 8'h00), 1'b1, 1'b0);
    chk("R4 reg uses 6 bits", out_err, 2);
    addr_chk_en = 0;
    send(mk_reg(5'h1F, 6'h3F, 8'h00), 1'b1, 1'b0);
    chk("R4 check disabled", out_err, 0);
  endtask

  task automatic t_sum();
    int exp_s;
    addr_chk_en = 1; exp_dev = 5'h00; exp_addr = 6'd0;
    clear_sum();
    chk("R6 cleared", out_sum, 0);
    exp_s = 0;
    for (int c = 0; c < 12; c++) begin
      send(mk_chan(5'h00, 4'(c), 12'(100 + c)), 1'b0, 1'b0);
      if (c < 6) exp_s += 100 + c;
    end
    send(mk_reg(5'h00, 6'd0, 8'hFF), 1'b1, 1'b0);
    chk("R5 cells only, address fault still adds", out_sum, exp_s);
    send(mk_chan(5'h00, 4'd2, 12'h007), 1'b0, 1'b1);
    chk("R6 clear with word", out_sum, 7);
  endtask

  task automatic t_lim_reset();
    addr_chk_en = 0;
    send(mk_chan(5'h00, 4'd1, 12'd255), 1'b0, 1'b0);
    chk("R9 reset high", {ev_rise, ev_fall}, 2'b10);
    send(mk_chan(5'h00, 4'd1, 12'd0), 1'b0, 1'b0);
    chk("R9 reset low", {ev_rise, ev_fall}, 2'b01);
    send(mk_chan(5'h00, 4'd1, 12'd100), 1'b0, 1'b0);
    chk("R9 between", {ev_rise, ev_fall}, 2'b00);
    @(negedge clk);
    chk("R11 event pulse ends", {ev_rise, ev_fall}, 2'b00);
  endtask

  task automatic t_lim_cell();
    set_lim(2'd0, 8'h80); set_lim(2'd1, 8'h40);
    send(mk_chan(5'h00, 4'd4, 12'h080), 1'b0, 1'b0);
    chk("R7 at high", {ev_rise, ev_fall}, 2'b10);
    send(mk_chan(5'h00, 4'd4, 12'h07F), 1'b0, 1'b0);
    chk("R7 below high", {ev_rise, ev_fall}, 2'b00);
    send(mk_chan(5'h00, 4'd4, 12'h040), 1'b0, 1'b0);
    chk("R7 at low", {ev_rise, ev_fall}, 2'b01);
    send(mk_chan(5'h00, 4'd4, 12'h041), 1'b0, 1'b0);
    chk("R7 above low", {ev_rise, ev_fall}, 2'b00);
    send(mk_chan(5'h00, 4'd4, 12'hFFF), 1'b0, 1'b0);
    chk("R7 wide result", {ev_rise, ev_fall}, 2'b10);
    set_lim(2'd0, 8'h10); set_lim(2'd1, 8'h20);
    send(mk_chan(5'h00, 4'd0, 12'h018), 1'b0, 1'b0);
    chk("R7 rising priority", {ev_rise, ev_fall}, 2'b10);
  endtask

  task automatic t_lim_aux();
    set_lim(2'd0, 8'h80); set_lim(2'd1, 8'h40);
    set_lim(2'd2, 8'h30); set_lim(2'd3, 8'h05);
    send(mk_chan(5'h00, 4'd7, 12'h030), 1'b0, 1'b0);
    chk("R8 aux high", {ev_rise, ev_fall}, 2'b10);
    send(mk_chan(5'h00, 4'd11, 12'h020), 1'b0, 1'b0);
    chk("R8 aux between", {ev_rise, ev_fall}, 2'b00);
    send(mk_chan(5'h00, 4'd6, 12'h005), 1'b0, 1'b0);
    chk("R8 aux low", {ev_rise, ev_fall}, 2'b01);
    send(mk_chan(5'h00, 4'd5, 12'h030), 1'b0, 1'b0);
    chk("R8 cell ignores aux", {ev_rise, ev_fall}, 2'b01);
  endtask

  task automatic t_full();
    clear_sum();
    for (int d = 0; d < 8; d++)
      for (int c = 0; c < 6; c++)
        send(mk_chan(5'(d), 4'(c), 12'hFFF), 1'b0, 1'b0);
    chk("R12 full scale", out_sum, 196560);
  endtask

  initial begin
    rst_n = 0; frm_valid = 0; frm_data = '0; frm_kind = 0; scan_clr = 0;
    addr_chk_en = 0; exp_dev = '0; exp_addr = '0;
    thr_wr = 0; thr_sel = '0; thr_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lim_reset();
    t_chan_decode();
    t_reg_decode();
    t_crc();
    t_addr();
    t_sum();
    t_lim_cell();
    t_lim_aux();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule